// File: doc/BRIEF.md
# Event Counter Bank with Limit Interrupts

This block holds a bank of event counters. Each counter picks one condition from a wider set of single-cycle event pulses and counts it. Software loads a start value and a limit value into each counter. When a counter's increment makes it equal to its limit, the counter sets a sticky flag. If that counter's interrupt enable is set, the flag feeds one shared interrupt line. The counter does not stop or reload at the limit. It keeps counting, so events that arrive while the interrupt is being serviced are still counted.

A snapshot command copies every counter into its own snapshot register on the same edge, so software reads a moving count without tearing. A name port returns an eight-character ASCII label for each condition. The label comes back as two 32-bit words, and the byte order does not depend on the host's endianness.

Access is through a simple word-addressed port. A write takes effect on the clock edge where `reg_wr` is high. Read data is registered and appears one cycle after the address.

Address bit 8 chooses the space. When it is 0, bits 2:0 select a global register: 0 run mask, 1 interrupt enable mask, 2 flag status, 3 snapshot command, 4 name select, 5 name low word, 6 name high word. When it is 1, bits 7:3 give the counter index and bits 2:0 select a per-counter field: 0 count low, 1 count high, 2 limit low, 3 limit high, 4 snapshot low, 5 snapshot high, 6 condition select.

Top module: `evt_count_unit`

## Requirements
- R1: Writing per-counter field 0 sets count bits 31:0, and writing field 1 sets count bits 47:32. Counting continues from the loaded value, and a carry from bit 31 into bit 32 is kept.
- R2: A counter adds exactly one for each cycle in which the event pulse selected by its field 6 is high. Pulses on any other condition leave it unchanged.
- R3: Reaching the limit neither stops nor clears the counter. Later events keep incrementing it.
- R4: Counter i's flag, which is bit i of global register 2, sets on the clock edge where an increment makes the count equal to the limit (fields 2 and 3). The flag stays set until a write to register 2 with bit i = 1. A write with bit i = 0 leaves it set.
- R5: While run-mask bit i (global register 0) is 0, counter i ignores event pulses and holds its value.
- R6: A write to global register 3 copies all counters into their snapshots on the same edge. Fields 4 and 5 read the low 32 bits and the upper 16 bits. An event counted on that same edge is not in the snapshot.
- R7: `irq_out` goes high one cycle after any flag is set. It returns low only after every set flag has been cleared.
- R8: A counter whose enable bit (global register 1) is 0 never sets its flag at the limit, but it still counts.
- R9: If a flag-clearing write and a new limit hit for the same counter fall on the same edge, the flag stays set.
- R10: After writing condition index k to global register 4, register 5 returns the ASCII bytes 'C','N','D',hex(k[7:4]) and register 6 returns hex(k[3:0]),'_','_','_'. The first character of each word is in bits 7:0, and hex digits use uppercase letters.
- R11: After reset the counts, snapshots, run mask, enable mask, flags and `irq_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_pulse | input | NCOND | One pulse line per countable condition |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | AW | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq_out | output | 1 | OR of all counter flags, registered |

## Verification
Two pairs of functions can fall on the same edge: a limit hit together with a write that clears the flag, and a counted event together with the snapshot command. The bench provokes each pair by raising the event pulse and the register write in the same cycle. For the first pair, it judges the result by reading the status register, where the flag must still be set. For the second pair, it reads the snapshot, which must hold the pre-increment value, and then takes a second snapshot, which must show the increment.

// File: rtl/ecu_pkg.sv
package ecu_pkg;
  // global register offsets (addr[2:0] with the space bit clear)
  localparam logic [2:0] G_RUN  = 3'd0;
  localparam logic [2:0] G_IEN  = 3'd1;
  localparam logic [2:0] G_STAT = 3'd2;
  localparam logic [2:0] G_SNAP = 3'd3;
  localparam logic [2:0] G_NSEL = 3'd4;
  localparam logic [2:0] G_NLO  = 3'd5;
  localparam logic [2:0] G_NHI  = 3'd6;
  // per-counter field offsets
  localparam logic [2:0] F_CLO  = 3'd0;
  localparam logic [2:0] F_CHI  = 3'd1;
  localparam logic [2:0] F_LLO  = 3'd2;
  localparam logic [2:0] F_LHI  = 3'd3;
  localparam logic [2:0] F_SLO  = 3'd4;
  localparam logic [2:0] F_SHI  = 3'd5;
  localparam logic [2:0] F_SEL  = 3'd6;

  function automatic logic [7:0] hex_char(input logic [3:0] n);
    return (n < 4'd10) ? (8'h30 + {4'd0, n}) : (8'h37 + {4'd0, n});
  endfunction

  // label "CNDxx___", first character in the least significant byte
  function automatic logic [63:0] cond_label(input int idx);
    logic [7:0] k;
    k = 8'(idx);
    return {8'h5F, 8'h5F, 8'h5F, hex_char(k[3:0]),
            hex_char(k[7:4]), 8'h44, 8'h4E, 8'h43};
  endfunction
endpackage

// File: rtl/ecu_counter.sv
module ecu_counter #(
  parameter int CW = 48
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          ev,
  input  logic          ld_lo,
  input  logic          ld_hi,
  input  logic          lim_lo,
  input  logic          lim_hi,
  input  logic [31:0]   wdata,
  input  logic          irq_en,
  input  logic          snap,
  input  logic          clr,
  output logic [CW-1:0] snap_q,
  output logic [CW-1:0] lim_q,
  output logic          flag
);
  localparam int HW = CW - 32;

  logic [CW-1:0] cnt, cnt_nx;
  logic          step, hit;

  always_comb begin
    step   = run & ev;
    cnt_nx = cnt;
    if (step) cnt_nx = cnt + 1'b1;
    if (ld_lo) cnt_nx[31:0] = wdata;
    if (ld_hi) cnt_nx[CW-1:32] = wdata[HW-1:0];
    hit = step & ~ld_lo & ~ld_hi & irq_en & (cnt_nx == lim_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      snap_q <= '0;
      lim_q  <= '1;
      flag   <= 1'b0;
    end else begin
      cnt <= cnt_nx;
      if (lim_lo) lim_q[31:0] <= wdata;
      if (lim_hi) lim_q[CW-1:32] <= wdata[HW-1:0];
      if (snap) snap_q <= cnt;
      if (hit) flag <= 1'b1;        // set beats clear (R9)
      else if (clr) flag <= 1'b0;
    end
  end

  a_r3_runs_past_limit: assert property (@(posedge clk) disable iff (rst)
    (step && !ld_lo && !ld_hi && cnt == lim_q) |=> cnt == $past(cnt) + 1'b1);
  a_r4_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr) |=> flag);
  a_r5_hold_when_stopped: assert property (@(posedge clk) disable iff (rst)
    (!run && !ld_lo && !ld_hi) |=> $stable(cnt));
  a_r6_snap_capture: assert property (@(posedge clk) disable iff (rst)
    snap |=> snap_q == $past(cnt));
  a_r8_no_flag_disabled: assert property (@(posedge clk) disable iff (rst)
    (!irq_en && !flag) |=> !flag);
endmodule

// File: rtl/ecu_name_rom.sv
module ecu_name_rom #(
  parameter int NCOND = 8,
  parameter int SW    = 3
) (
  input  logic [SW-1:0] sel,
  output logic [31:0]   lo,
  output logic [31:0]   hi
);
  logic [63:0] tbl [NCOND];

  for (genvar g = 0; g < NCOND; g++) begin : g_lbl
    assign tbl[g] = ecu_pkg::cond_label(g);
  end

  always_comb begin
    if (32'(sel) < NCOND) begin
      lo = tbl[sel][31:0];
      hi = tbl[sel][63:32];
    end else begin
      lo = '0;
      hi = '0;
    end
  end
endmodule

// File: rtl/evt_count_unit.sv
module evt_count_unit #(
  parameter int NCNT  = 4,
  parameter int CW    = 48,
  parameter int NCOND = 8,
  parameter int AW    = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCOND-1:0] ev_pulse,
  input  logic             reg_wr,
  input  logic [AW-1:0]    reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             irq_out
);
  import ecu_pkg::*;

  localparam int IW  = AW - 4;
  localparam int CSW = (NCOND > 1) ? $clog2(NCOND) : 1;
  localparam int HW  = CW - 32;

  logic            is_cnt, wr_g, wr_c, snap_cmd;
  logic [IW-1:0]   idx;
  logic [2:0]      fld;
  logic [NCNT-1:0] run_q, ien_q, flags, clr_vec;
  logic [CSW-1:0]  nsel_q;
  logic [CSW-1:0]  sel_q  [NCNT];
  logic [CW-1:0]   snap_a [NCNT];
  logic [CW-1:0]   lim_a  [NCNT];
  logic [31:0]     nm_lo, nm_hi, rd_nx;

  assign is_cnt   = reg_addr[AW-1];
  assign idx      = reg_addr[AW-2:3];
  assign fld      = reg_addr[2:0];
  assign wr_g     = reg_wr & ~is_cnt;
  assign wr_c     = reg_wr & is_cnt;
  assign snap_cmd = wr_g & (fld == G_SNAP);
  assign clr_vec  = (wr_g && fld == G_STAT) ? reg_wdata[NCNT-1:0] : '0;

  for (genvar g = 0; g < NCNT; g++) begin : g_ctr
    logic sel_me, ev_g;
    assign sel_me = wr_c && (32'(idx) == g);
    assign ev_g   = (32'(sel_q[g]) < NCOND) ? ev_pulse[sel_q[g]] : 1'b0;

    ecu_counter #(.CW(CW)) u_ctr (
      .clk    (clk),
      .rst    (rst),
      .run    (run_q[g]),
      .ev     (ev_g),
      .ld_lo  (sel_me && fld == F_CLO),
      .ld_hi  (sel_me && fld == F_CHI),
      .lim_lo (sel_me && fld == F_LLO),
      .lim_hi (sel_me && fld == F_LHI),
      .wdata  (reg_wdata),
      .irq_en (ien_q[g]),
      .snap   (snap_cmd),
      .clr    (clr_vec[g]),
      .snap_q (snap_a[g]),
      .lim_q  (lim_a[g]),
      .flag   (flags[g])
    );
  end

  ecu_name_rom #(.NCOND(NCOND), .SW(CSW)) u_names (
    .sel (nsel_q),
    .lo  (nm_lo),
    .hi  (nm_hi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= '0;
      ien_q  <= '0;
      nsel_q <= '0;
      for (int i = 0; i < NCNT; i++) sel_q[i] <= '0;
    end else begin
      if (wr_g && fld == G_RUN)  run_q  <= reg_wdata[NCNT-1:0];
      if (wr_g && fld == G_IEN)  ien_q  <= reg_wdata[NCNT-1:0];
      if (wr_g && fld == G_NSEL) nsel_q <= reg_wdata[CSW-1:0];
      for (int i = 0; i < NCNT; i++)
        if (wr_c && fld == F_SEL && 32'(idx) == i) sel_q[i] <= reg_wdata[CSW-1:0];
    end
  end

  always_comb begin
    rd_nx = '0;
    if (!is_cnt) begin
      case (fld)
        G_RUN:   rd_nx = 32'(run_q);
        G_IEN:   rd_nx = 32'(ien_q);
        G_STAT:  rd_nx = 32'(flags);
        G_NSEL:  rd_nx = 32'(nsel_q);
        G_NLO:   rd_nx = nm_lo;
        G_NHI:   rd_nx = nm_hi;
        default: rd_nx = '0;
      endcase
    end else if (32'(idx) < NCNT) begin
      case (fld)
        F_LLO:   rd_nx = lim_a[idx][31:0];
        F_LHI:   rd_nx = 32'(lim_a[idx][CW-1:32]);
        F_SLO:   rd_nx = snap_a[idx][31:0];
        F_SHI:   rd_nx = 32'(snap_a[idx][CW-1:32]);
        F_SEL:   rd_nx = 32'(sel_q[idx]);
        default: rd_nx = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq_out   <= 1'b0;
    end else begin
      reg_rdata <= rd_nx;
      irq_out   <= |flags;
    end
  end

  a_r7_irq_follows_flags: assert property (@(posedge clk) disable iff (rst)
    (flags != '0) |=> irq_out);
  a_r7_irq_drops_when_clear: assert property (@(posedge clk) disable iff (rst)
    (flags == '0) |=> !irq_out);
  a_r11_width_ok: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> (HW >= 1 && HW <= 32));
endmodule

// File: tb/evt_count_unit_tb.sv
module evt_count_unit_tb;
  localparam int CLK_P = 10;
  localparam int NCNT  = 4;
  localparam int NCOND = 8;
  localparam int AW    = 9;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [NCOND-1:0] ev_pulse = '0;
  logic             reg_wr = 1'b0;
  logic [AW-1:0]    reg_addr = '0;
  logic [31:0]      reg_wdata = '0;
  logic [31:0]      reg_rdata;
  logic             irq_out;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  evt_count_unit #(.NCNT(NCNT), .CW(48), .NCOND(NCOND), .AW(AW)) u_dut (
    .clk(clk), .rst(rst), .ev_pulse(ev_pulse), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_out(irq_out)
  );

  function automatic logic [AW-1:0] ga(input int f);
    return {1'b0, 5'd0, 3'(f)};
  endfunction
  function automatic logic [AW-1:0] ca(input int i, input int f);
    return {1'b1, 5'(i), 3'(f)};
  endfunction
  function automatic logic [7:0] hx(input int n);
    return (n < 10) ? 8'(48 + n) : 8'(55 + n);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic pulse(input int c, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); ev_pulse = '0; ev_pulse[c] = 1'b1;
      @(negedge clk); ev_pulse = '0;
    end
  endtask

  task automatic snap_of(input int i, output logic [63:0] v);
    logic [31:0] lo, hi;
    wr(ga(3), 0);
    rd(ca(i, 4), lo);
    rd(ca(i, 5), hi);
    v = {hi, lo};
  endtask

  task automatic setup(input int i, input int c, input logic [47:0] st, input logic [47:0] lim);
    wr(ca(i, 6), c);
    wr(ca(i, 2), lim[31:0]);
    wr(ca(i, 3), 32'(lim[47:32]));
    wr(ca(i, 0), st[31:0]);
    wr(ca(i, 1), 32'(st[47:32]));
  endtask

  task automatic t_reset;
    logic [31:0] d; logic [63:0] v;
    rd(ga(2), d); chk("R11 flags at reset", d, 0);
    rd(ga(0), d); chk("R11 run mask at reset", d, 0);
    chk("R11 irq at reset", irq_out, 0);
    snap_of(0, v); chk("R11 count at reset", v, 0);
  endtask

  task automatic t_count;
    logic [63:0] v;
    setup(0, 2, 48'd10, 48'hFFFF_FFFF_FFFF);
    wr(ga(0), 32'h1);
    pulse(2, 5);
    snap_of(0, v); chk("R1 R2 count from loaded start", v, 15);
    pulse(3, 4);
    snap_of(0, v); chk("R2 other condition ignored", v, 15);
    wr(ga(0), 32'h0);
    pulse(2, 3);
    snap_of(0, v); chk("R5 stopped counter holds", v, 15);
  endtask

  task automatic t_limit;
    logic [31:0] d; logic [63:0] v;
    setup(1, 3, 48'h0000_FFFF_FFFE, 48'h0001_0000_0001);
    wr(ga(1), 32'h2);
    wr(ga(0), 32'h2);
    pulse(3, 2);
    snap_of(1, v); chk("R1 carry into high word", v, 64'h1_0000_0000);
    rd(ga(2), d); chk("R4 no flag before limit", d[1], 0);
    pulse(3, 1);
    rd(ga(2), d); chk("R4 flag at limit", d[1], 1);
    chk("R7 irq raised", irq_out, 1);
    pulse(3, 2);
    snap_of(1, v); chk("R3 counts past limit", v, 64'h1_0000_0003);
    wr(ga(2), 32'h0);
    rd(ga(2), d); chk("R4 write of zero keeps flag", d[1], 1);
    wr(ga(2), 32'h2);
    @(negedge clk);
    rd(ga(2), d); chk("R4 write one clears flag", d[1], 0);
    chk("R7 irq low after clear", irq_out, 0);
  endtask

  task automatic t_irq_or;
    logic [31:0] d;
    setup(0, 2, 48'd19, 48'd20);
    setup(1, 3, 48'd15, 48'd16);
    wr(ga(1), 32'h3);
    wr(ga(0), 32'h3);
    pulse(2, 1);
    pulse(3, 1);
    rd(ga(2), d); chk("R4 two flags set", d[1:0], 2'b11);
    wr(ga(2), 32'h1);
    @(negedge clk);
    chk("R7 irq held by remaining flag", irq_out, 1);
    wr(ga(2), 32'h2);
    @(negedge clk);
    chk("R7 irq low once all cleared", irq_out, 0);
  endtask

  task automatic t_enable;
    logic [31:0] d; logic [63:0] v;
    setup(2, 4, 48'd4, 48'd5);
    wr(ga(1), 32'h0);
    wr(ga(0), 32'h4);
    pulse(4, 1);
    rd(ga(2), d); chk("R8 no flag when disabled", d[2], 0);
    chk("R8 irq stays low", irq_out, 0);
    snap_of(2, v); chk("R8 still counts", v, 5);
  endtask

  task automatic t_collide;
    logic [31:0] d; logic [63:0] v;
    setup(0, 2, 48'd9, 48'd10);
    wr(ga(1), 32'h1);
    wr(ga(0), 32'h1);
    pulse(2, 1);
    wr(ca(0, 0), 32'd9);
    @(negedge clk);
    ev_pulse = '0; ev_pulse[2] = 1'b1;
    reg_wr = 1'b1; reg_addr = ga(2); reg_wdata = 32'h1;
    @(negedge clk);
    ev_pulse = '0; reg_wr = 1'b0;
    rd(ga(2), d); chk("R9 hit beats clear", d[0], 1);
    @(negedge clk);
    ev_pulse = '0; ev_pulse[2] = 1'b1;
    reg_wr = 1'b1; reg_addr = ga(3); reg_wdata = 0;
    @(negedge clk);
    ev_pulse = '0; reg_wr = 1'b0;
    rd(ca(0, 4), d); chk("R6 snapshot excludes same-edge event", d, 10);
    snap_of(0, v); chk("R6 later snapshot sees event", v, 11);
    wr(ga(2), 32'hF);
    wr(ga(0), 32'h0);
  endtask

  task automatic t_names;
    logic [31:0] lo, hi;
    for (int k = 0; k < NCOND; k += 5) begin
      wr(ga(4), k);
      rd(ga(5), lo);
      rd(ga(6), hi);
      chk("R10 name low word", lo, {hx(k / 16), 8'h44, 8'h4E, 8'h43});
      chk("R10 name high word", hi, {8'h5F, 8'h5F, 8'h5F, hx(k % 16)});
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_count();
    t_limit();
    t_irq_or();
    t_enable();
    t_collide();
    t_names();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule